// File: doc/BRIEF.md
# Multi-Hart Debug Run Controller

This block holds the per-hart run-control state that a debug module keeps for a set of harts. A debugger-side register decoder drives it. That decoder supplies the index of a single selected hart, an optional multi-hart selection mask, and a control-write strobe. The strobe carries fields for halt, resume, reset acknowledge, setting and clearing halt-on-reset, and the hart reset level. For each hart the block drives a halt request, a resume request, a halt-on-reset request and a reset line. It takes back the hart's halted, running, unavailable and reset-seen indications.

The block reduces the state of the selected harts into any/all flag pairs. These cover halted, running, unavailable, nonexistent, resume-acknowledged and has-been-reset. A decoder can place the flags directly into its status register. The selection mask is loaded one 32-bit window at a time. Each write goes to the window chosen by a window index.

All state clears on the asynchronous power-up reset. It also clears on any clock edge at which the module-active input is low.

Top module: `hart_runctl`

## Requirements
- R1: With `rst_n` low, or at any clock edge with `dm_active` low, every per-hart state bit and every mask bit clears. The resume-ack bits take the `ACK_INIT` value, which is 0 by default. Writes made while `dm_active` is low have no effect.
- R2: Hart i is selected when `hart_sel` equals i, or when `mask_en` is 1 and mask bit i is 1. A pulse on `win_wr` loads `win_data` bit j into mask bit `win_sel`*32+j. Changing `mask_en` leaves the mask contents unchanged.
- R3: A control write with the halt field at 1 sets `halt_req` on the next edge for each selected hart that is not halted. A write with the halt field at 0 clears `halt_req` for the selected harts. `halt_req` of a hart clears on the edge after that hart reports halted.
- R4: A control write with the resume field at 1 clears the resume-ack bit of each selected hart and records a pending resume for it. `resume_req[i]` is high while the resume is pending and hart i reports halted. The pending resume ends, and the ack bit sets, on the edge after the hart reports running.
- R5: A resume write to a selected hart that is already running never raises its `resume_req`. Its resume-ack bit reads 0 right after the write and 1 one cycle later.
- R6: The has-been-reset bit of hart i sets on the edge after `hart_rst_seen[i]` is high, and then holds. A write with the acknowledge field at 1 clears it for the selected harts. A reset indication in the same cycle as the acknowledge wins.
- R7: `hor_req` of a selected hart sets on a write with the set-halt-on-reset field at 1. It clears only on a write with the clear field at 1 while that hart is selected. If both fields are 1 in the same write, the clear wins.
- R8: On every control write, `hart_rst` of each selected hart takes the value of `cmd_hart_rst`. Unselected harts hold their value.
- R9: Each any_* flag is the OR, and each all_* flag is the AND, of the state over the selected harts. The halted, running and unavailable flags use the hart inputs. The resume-ack and has-been-reset flags use the stored bits. Every all_* flag is 0 when nothing is selected.
- R10: A `hart_sel` value of `NHARTS` or above selects a nonexistent hart and sets `any_nonexist`. `all_nonexist` is 1 only when no existing hart is selected as well. A selected nonexistent hart forces the halted, running, unavailable, resume-ack and reset all_* flags to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-up reset, active low |
| dm_active | input | 1 | Module active; low clears all state |
| hart_sel | input | SELW | Index of the single selected hart |
| mask_en | input | 1 | Adds the mask to the selection |
| win_wr | input | 1 | Mask window write strobe |
| win_sel | input | WSW | Mask window index |
| win_data | input | WINW | Mask window contents |
| cmd_wr | input | 1 | Control write strobe |
| cmd_halt | input | 1 | Halt field of the control write |
| cmd_resume | input | 1 | Resume field |
| cmd_ack_rst | input | 1 | Has-been-reset acknowledge field |
| cmd_set_hor | input | 1 | Set halt-on-reset field |
| cmd_clr_hor | input | 1 | Clear halt-on-reset field |
| cmd_hart_rst | input | 1 | Hart reset level field |
| hart_halted | input | NHARTS | Per-hart halted indication |
| hart_running | input | NHARTS | Per-hart running indication |
| hart_unavail | input | NHARTS | Per-hart unavailable indication |
| hart_rst_seen | input | NHARTS | Per-hart pulse: hart went through reset |
| halt_req | output | NHARTS | Per-hart halt request |
| resume_req | output | NHARTS | Per-hart resume request |
| hor_req | output | NHARTS | Per-hart halt-on-reset request |
| hart_rst | output | NHARTS | Per-hart reset |
| any_halted | output | 1 | Some selected hart is halted |
| all_halted | output | 1 | All selected harts are halted |
| any_running | output | 1 | Some selected hart is running |
| all_running | output | 1 | All selected harts are running |
| any_unavail | output | 1 | Some selected hart is unavailable |
| all_unavail | output | 1 | All selected harts are unavailable |
| any_nonexist | output | 1 | A nonexistent hart is selected |
| all_nonexist | output | 1 | Only a nonexistent hart is selected |
| any_resack | output | 1 | Some selected hart has acknowledged resume |
| all_resack | output | 1 | All selected harts have acknowledged resume |
| any_haverst | output | 1 | Some selected hart has been reset |
| all_haverst | output | 1 | All selected harts have been reset |

## Verification
The bound checker checks the following on every cycle:
- a halted hart never keeps a halt request into the next cycle;
- halt-on-reset and has-been-reset bits fall only on their clearing writes or on module deactivation;
- a resume write leaves the ack of the selected harts at 0;
- the mask holds between window writes;
- every all_* flag implies its any_* flag.

Only the bench scenarios can show that the any/all reductions give the right values over mixed single and mask selections, including ones that cross the window boundary. The same holds for the resume handshake timing on halted and running harts, the set-versus-clear priorities, and the effect of deactivation on writes.

// File: rtl/hart_runctl.sv
module hart_runctl #(
  parameter int NHARTS   = 36,
  parameter int SELW     = 6,
  parameter int WINW     = 32,
  parameter bit ACK_INIT = 1'b0,
  localparam int NWIN    = (NHARTS + WINW - 1) / WINW,
  localparam int WSW     = (NWIN > 1) ? $clog2(NWIN) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dm_active,
  input  logic [SELW-1:0]   hart_sel,
  input  logic              mask_en,
  input  logic              win_wr,
  input  logic [WSW-1:0]    win_sel,
  input  logic [WINW-1:0]   win_data,
  input  logic              cmd_wr,
  input  logic              cmd_halt,
  input  logic              cmd_resume,
  input  logic              cmd_ack_rst,
  input  logic              cmd_set_hor,
  input  logic              cmd_clr_hor,
  input  logic              cmd_hart_rst,
  input  logic [NHARTS-1:0] hart_halted,
  input  logic [NHARTS-1:0] hart_running,
  input  logic [NHARTS-1:0] hart_unavail,
  input  logic [NHARTS-1:0] hart_rst_seen,
  output logic [NHARTS-1:0] halt_req,
  output logic [NHARTS-1:0] resume_req,
  output logic [NHARTS-1:0] hor_req,
  output logic [NHARTS-1:0] hart_rst,
  output logic              any_halted,
  output logic              all_halted,
  output logic              any_running,
  output logic              all_running,
  output logic              any_unavail,
  output logic              all_unavail,
  output logic              any_nonexist,
  output logic              all_nonexist,
  output logic              any_resack,
  output logic              all_resack,
  output logic              any_haverst,
  output logic              all_haverst
);

  logic [NHARTS-1:0] mask, sel, hreq, rpend, rack, hrs, hor, hrst_q;
  logic [NHARTS-1:0] mask_n, hreq_n, rpend_n, rack_n, hrs_n, hor_n, hrst_n;
  logic sel_nx, has_sel, all_ok;

  assign sel_nx = int'(hart_sel) >= NHARTS;

  always_comb begin
    for (int i = 0; i < NHARTS; i++) begin
      sel[i]     = (int'(hart_sel) == i) || (mask_en && mask[i]);
      mask_n[i]  = (win_wr && int'(win_sel) == i / WINW) ? win_data[i % WINW] : mask[i];
      hreq_n[i]  = (cmd_wr && sel[i]) ? (cmd_halt && !hart_halted[i])
                                      : (hreq[i] && !hart_halted[i]);
      rpend_n[i] = (cmd_wr && sel[i] && cmd_resume) ? 1'b1 : (rpend[i] && !hart_running[i]);
      rack_n[i]  = (cmd_wr && sel[i] && cmd_resume) ? 1'b0 : (rack[i] || (rpend[i] && hart_running[i]));
      hrs_n[i]   = hart_rst_seen[i] || (hrs[i] && !(cmd_wr && sel[i] && cmd_ack_rst));
      hor_n[i]   = (cmd_wr && sel[i] && cmd_clr_hor) ? 1'b0 : (hor[i] || (cmd_wr && sel[i] && cmd_set_hor));
      hrst_n[i]  = (cmd_wr && sel[i]) ? cmd_hart_rst : hrst_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask   <= '0;
      hreq   <= '0;
      rpend  <= '0;
      rack   <= {NHARTS{ACK_INIT}};
      hrs    <= '0;
      hor    <= '0;
      hrst_q <= '0;
    end else if (!dm_active) begin
      mask   <= '0;
      hreq   <= '0;
      rpend  <= '0;
      rack   <= {NHARTS{ACK_INIT}};
      hrs    <= '0;
      hor    <= '0;
      hrst_q <= '0;
    end else begin
      mask   <= mask_n;
      hreq   <= hreq_n;
      rpend  <= rpend_n;
      rack   <= rack_n;
      hrs    <= hrs_n;
      hor    <= hor_n;
      hrst_q <= hrst_n;
    end
  end

  assign halt_req   = hreq;
  assign resume_req = rpend & hart_halted;
  assign hor_req    = hor;
  assign hart_rst   = hrst_q;

  assign has_sel = |sel;
  assign all_ok  = has_sel && !sel_nx;

  assign any_halted   = |(hart_halted & sel);
  assign all_halted   = all_ok && &(hart_halted | ~sel);
  assign any_running  = |(hart_running & sel);
  assign all_running  = all_ok && &(hart_running | ~sel);
  assign any_unavail  = |(hart_unavail & sel);
  assign all_unavail  = all_ok && &(hart_unavail | ~sel);
  assign any_resack   = |(rack & sel);
  assign all_resack   = all_ok && &(rack | ~sel);
  assign any_haverst  = |(hrs & sel);
  assign all_haverst  = all_ok && &(hrs | ~sel);
  assign any_nonexist = sel_nx;
  assign all_nonexist = sel_nx && !has_sel;

endmodule

// File: rtl/hart_runctl_chk.sv
module hart_runctl_chk #(
  parameter int NHARTS = 36
) (
  input logic              clk,
  input logic              rst_n,
  input logic              dm_active,
  input logic              cmd_wr,
  input logic              cmd_resume,
  input logic              cmd_ack_rst,
  input logic              cmd_clr_hor,
  input logic              win_wr,
  input logic [NHARTS-1:0] hart_halted,
  input logic [NHARTS-1:0] halt_req,
  input logic [NHARTS-1:0] hor_req,
  input logic [NHARTS-1:0] sel,
  input logic [NHARTS-1:0] rack,
  input logic [NHARTS-1:0] hrs,
  input logic [NHARTS-1:0] mask,
  input logic              any_halted,
  input logic              all_halted,
  input logic              any_running,
  input logic              all_running,
  input logic              any_unavail,
  input logic              all_unavail,
  input logic              all_nonexist,
  input logic              any_resack,
  input logic              all_resack,
  input logic              any_haverst,
  input logic              all_haverst
);

  a_r3_halted_drops_req: assert property (@(posedge clk) disable iff (!rst_n)
    ((halt_req & $past(hart_halted)) == '0));

  a_r4_resume_clears_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && cmd_resume && dm_active) |=> ((rack & $past(sel)) == '0));

  a_r6_haverst_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(hrs) & ~hrs) != '0) |-> ($past(cmd_wr && cmd_ack_rst) || !$past(dm_active)));

  a_r7_hor_clear_only: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(hor_req) & ~hor_req) != '0) |-> ($past(cmd_wr && cmd_clr_hor) || !$past(dm_active)));

  a_r2_mask_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!win_wr && dm_active) |=> $stable(mask));

  a_r9_all_implies_any: assert property (@(posedge clk) disable iff (!rst_n)
    (!all_halted || any_halted) && (!all_running || any_running) &&
    (!all_unavail || any_unavail) && (!all_resack || any_resack) &&
    (!all_haverst || any_haverst));

  a_r10_nonexist_alone: assert property (@(posedge clk) disable iff (!rst_n)
    all_nonexist |-> (!any_halted && !any_running && !any_unavail));

endmodule

bind hart_runctl hart_runctl_chk #(.NHARTS(NHARTS)) u_chk (
  .clk(clk), .rst_n(rst_n), .dm_active(dm_active), .cmd_wr(cmd_wr),
  .cmd_resume(cmd_resume), .cmd_ack_rst(cmd_ack_rst), .cmd_clr_hor(cmd_clr_hor),
  .win_wr(win_wr), .hart_halted(hart_halted), .halt_req(halt_req), .hor_req(hor_req),
  .sel(sel), .rack(rack), .hrs(hrs), .mask(mask),
  .any_halted(any_halted), .all_halted(all_halted), .any_running(any_running),
  .all_running(all_running), .any_unavail(any_unavail), .all_unavail(all_unavail),
  .all_nonexist(all_nonexist), .any_resack(any_resack), .all_resack(all_resack),
  .any_haverst(any_haverst), .all_haverst(all_haverst)
);

// File: tb/tb_hart_runctl.sv
module tb_hart_runctl;
  localparam int N = 36;

  logic clk = 1'b0;
  logic rst_n = 1'b0, dm_active = 1'b1;
  logic [5:0] hart_sel = '0;
  logic mask_en = 1'b0, win_wr = 1'b0;
  logic [1:0] win_sel_w = '0;
  logic [0:0] win_sel;
  logic [31:0] win_data = '0;
  logic cmd_wr = 0, cmd_halt = 0, cmd_resume = 0, cmd_ack_rst = 0;
  logic cmd_set_hor = 0, cmd_clr_hor = 0, cmd_hart_rst = 0;
  logic [N-1:0] hh   = 36'h0_0000_000F;
  logic [N-1:0] hrun = 36'h0_FFFF_FFF0;
  logic [N-1:0] hun  = 36'hF_0000_0000;
  logic [N-1:0] hrs_in = '0;
  logic [N-1:0] halt_req, resume_req, hor_req, hart_rst;
  logic any_halted, all_halted, any_running, all_running, any_unavail, all_unavail;
  logic any_nonexist, all_nonexist, any_resack, all_resack, any_haverst, all_haverst;
  int checks = 0, errors = 0;

  assign win_sel = win_sel_w[0:0];

  always #10 clk = ~clk;

  hart_runctl dut (
    .clk(clk), .rst_n(rst_n), .dm_active(dm_active), .hart_sel(hart_sel),
    .mask_en(mask_en), .win_wr(win_wr), .win_sel(win_sel), .win_data(win_data),
    .cmd_wr(cmd_wr), .cmd_halt(cmd_halt), .cmd_resume(cmd_resume),
    .cmd_ack_rst(cmd_ack_rst), .cmd_set_hor(cmd_set_hor), .cmd_clr_hor(cmd_clr_hor),
    .cmd_hart_rst(cmd_hart_rst), .hart_halted(hh), .hart_running(hrun),
    .hart_unavail(hun), .hart_rst_seen(hrs_in), .halt_req(halt_req),
    .resume_req(resume_req), .hor_req(hor_req), .hart_rst(hart_rst),
    .any_halted(any_halted), .all_halted(all_halted), .any_running(any_running),
    .all_running(all_running), .any_unavail(any_unavail), .all_unavail(all_unavail),
    .any_nonexist(any_nonexist), .all_nonexist(all_nonexist),
    .any_resack(any_resack), .all_resack(all_resack),
    .any_haverst(any_haverst), .all_haverst(all_haverst));

  // {hart_sel[5:0], mask_en, halt a/A, run a/A, unav a/A, nonex a/A}
  localparam logic [14:0] VEC [7] = '{
    {6'd0,  1'b0, 8'hC0},
    {6'd5,  1'b0, 8'h30},
    {6'd5,  1'b1, 8'hA8},
    {6'd0,  1'b1, 8'h88},
    {6'd40, 1'b0, 8'h03},
    {6'd40, 1'b1, 8'h8A},
    {6'd33, 1'b0, 8'h0C}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] s, input logic me, input logic h, input logic r,
                    input logic a, input logic sh, input logic ch, input logic hr);
    @(negedge clk);
    hart_sel = s; mask_en = me; cmd_wr = 1'b1;
    cmd_halt = h; cmd_resume = r; cmd_ack_rst = a;
    cmd_set_hor = sh; cmd_clr_hor = ch; cmd_hart_rst = hr;
    @(negedge clk);
    cmd_wr = 1'b0;
  endtask

  task automatic win(input logic [1:0] ws, input logic [31:0] d);
    @(negedge clk);
    win_wr = 1'b1; win_sel_w = ws; win_data = d;
    @(negedge clk);
    win_wr = 1'b0;
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog actual running expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 halt_req", 64'(halt_req), 64'(0));
    chk("R1 resume_req", 64'(resume_req), 64'(0));
    chk("R1 hor_req", 64'(hor_req), 64'(0));
    chk("R1 hart_rst", 64'(hart_rst), 64'(0));
    chk("R1 resack/haverst", 64'({any_resack, any_haverst}), 64'(0));

    // R2 mask windows then R9 R10 table
    win(2'd0, 32'h3);
    win(2'd1, 32'h1);
    for (int k = 0; k < 7; k++) begin
      @(negedge clk);
      hart_sel = VEC[k][14:9];
      mask_en  = VEC[k][8];
      #1;
      chk("R2 R9 R10 table", 64'({any_halted, all_halted, any_running, all_running,
          any_unavail, all_unavail, any_nonexist, all_nonexist}), 64'(VEC[k][7:0]));
    end
    mask_en = 1'b0;

    // R3 halt
    wr(6'd5, 0, 1, 0, 0, 0, 0, 0);
    chk("R3 set", 64'(halt_req), 64'(1) << 5);
    hh[5] = 1'b1; hrun[5] = 1'b0;
    @(negedge clk);
    chk("R3 clear on halted", 64'(halt_req), 64'(0));
    wr(6'd0, 0, 1, 0, 0, 0, 0, 0);
    chk("R3 halted hart ignores", 64'(halt_req), 64'(0));
    wr(6'd6, 0, 1, 0, 0, 0, 0, 0);
    chk("R3 set hart6", 64'(halt_req), 64'(1) << 6);
    wr(6'd6, 0, 0, 0, 0, 0, 0, 0);
    chk("R3 write zero clears", 64'(halt_req), 64'(0));

    // R4 resume halted hart 5
    wr(6'd5, 0, 0, 1, 0, 0, 0, 0);
    chk("R4 resume_req", 64'(resume_req), 64'(1) << 5);
    chk("R4 ack low", 64'(any_resack), 64'(0));
    hh[5] = 1'b0; hrun[5] = 1'b1;
    #1;
    chk("R4 req drops when running", 64'(resume_req), 64'(0));
    @(negedge clk);
    chk("R4 ack set", 64'(all_resack), 64'(1));

    // R5 resume running hart 7
    wr(6'd7, 0, 0, 1, 0, 0, 0, 0);
    chk("R5 no resume_req", 64'(resume_req), 64'(0));
    chk("R5 ack low after write", 64'(all_resack), 64'(0));
    @(negedge clk);
    chk("R5 ack next cycle", 64'(all_resack), 64'(1));

    // R2 mask across windows and enable toggles
    win(2'd0, 32'h300);
    win(2'd1, 32'h2);
    @(negedge clk); mask_en = 1'b0;
    @(negedge clk); mask_en = 1'b1;
    @(negedge clk); mask_en = 1'b0;
    wr(6'd10, 1, 1, 0, 0, 0, 0, 0);
    chk("R2 mask halt", 64'(halt_req), (64'(1) << 8) | (64'(1) << 9) | (64'(1) << 10) | (64'(1) << 33));
    wr(6'd10, 0, 0, 0, 0, 0, 0, 0);
    chk("R2 single clear", 64'(halt_req), (64'(1) << 8) | (64'(1) << 9) | (64'(1) << 33));
    wr(6'd10, 1, 0, 0, 0, 0, 0, 0);
    chk("R2 mask clear", 64'(halt_req), 64'(0));

    // R6 havereset
    @(negedge clk); hrs_in[3] = 1'b1; hrs_in[4] = 1'b1;
    @(negedge clk); hrs_in = '0; hart_sel = 6'd3; mask_en = 1'b0;
    #1;
    chk("R6 set", 64'({any_haverst, all_haverst}), 64'(3));
    wr(6'd3, 0, 0, 0, 1, 0, 0, 0);
    chk("R6 ack clears", 64'(any_haverst), 64'(0));
    @(negedge clk); hart_sel = 6'd4;
    #1;
    chk("R6 unselected kept", 64'(all_haverst), 64'(1));
    @(negedge clk);
    hrs_in[3] = 1'b1; hart_sel = 6'd3; cmd_wr = 1'b1; cmd_ack_rst = 1'b1;
    @(negedge clk);
    cmd_wr = 1'b0; cmd_ack_rst = 1'b0; hrs_in = '0;
    chk("R6 reset wins over ack", 64'(any_haverst), 64'(1));

    // R7 halt-on-reset
    wr(6'd2, 0, 0, 0, 0, 1, 0, 0);
    chk("R7 set", 64'(hor_req), 64'(1) << 2);
    wr(6'd4, 0, 0, 0, 0, 0, 1, 0);
    chk("R7 unselected clear", 64'(hor_req), 64'(1) << 2);
    wr(6'd2, 0, 0, 0, 0, 0, 0, 0);
    chk("R7 plain write", 64'(hor_req), 64'(1) << 2);
    wr(6'd2, 0, 0, 0, 0, 1, 1, 0);
    chk("R7 clear wins", 64'(hor_req), 64'(0));

    // R8 hart reset
    wr(6'd1, 0, 0, 0, 0, 0, 0, 1);
    chk("R8 assert", 64'(hart_rst), 64'(1) << 1);
    wr(6'd2, 0, 0, 0, 0, 0, 0, 0);
    chk("R8 unselected hold", 64'(hart_rst), 64'(1) << 1);
    wr(6'd1, 0, 0, 0, 0, 0, 0, 0);
    chk("R8 release", 64'(hart_rst), 64'(0));

    // R1 module deactivation
    wr(6'd2, 0, 0, 0, 0, 1, 0, 0);
    wr(6'd1, 0, 0, 0, 0, 0, 0, 1);
    @(negedge clk); dm_active = 1'b0;
    wr(6'd9, 0, 1, 0, 0, 1, 0, 1);
    @(negedge clk); dm_active = 1'b1;
    #1;
    chk("R1 inactive hor", 64'(hor_req), 64'(0));
    chk("R1 inactive hart_rst", 64'(hart_rst), 64'(0));
    chk("R1 inactive halt write ignored", 64'(halt_req), 64'(0));
    hart_sel = 6'd3;
    #1;
    chk("R1 haverst cleared", 64'(any_haverst), 64'(0));
    hart_sel = 6'd5;
    #1;
    chk("R1 resack cleared", 64'(any_resack), 64'(0));
    wr(6'd10, 1, 1, 0, 0, 0, 0, 0);
    chk("R1 mask cleared", 64'(halt_req), 64'(1) << 10);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule